// File: doc/BRIEF.md
# Asynchronous Microprocessor Bus Slave with Ready Handshake

This block lets an external processor reach a small byte store over an asynchronous bus. The bus has an active-low select, active-low read and write strobes, an 11-bit address and 8-bit data. The block has a fast internal clock and passes select and both strobes through a two-flop synchronizer. It detects their edges on the synchronized copies, and from those edges it times each access.

A read starts when the read strobe falls. The byte is fetched from the store at that moment and held on the data pins until the strobe is released. A write also arms the ready timer when its strobe falls, but it only writes the store once the strobe rises, using the address and data last seen while the strobe was low. The ready pull-down begins a fixed number of clocks after the strobe falls. A configuration pin picks the shorter (early) or longer (normal) latency. The data and ready pads are returned to the pad ring as value and enable pairs, so the tristate and open-drain buffers sit outside the block.

Accesses that break the bus timing rules are dropped. These are: a strobe with select high, a write strobe that is too short, a strobe that falls too soon after the previous one, and a write that arrives too soon after select.

Top module: `async_bus_slave`

## Requirements
- R1: A read starts when `rd_n_i` falls while the block is idle. The byte stored at `addr_i` is latched at that point and presented on `data_o` with `data_oe_o` high. It stays unchanged until `rd_n_i` rises.
- R2: A write is committed to the store only after `wr_n_i` rises. It uses the `addr_i` and `data_i` values sampled on the last rising clock edge at which `wr_n_i` was low.
- R3: Count the first rising clock edge after a strobe falls as edge 1. For an accepted access, `rdy_pull_o` first reads high after edge 5 when `early_rdy_i` is 0, and after edge 4 when it is 1. It is low after edge 4 (normal mode) and after edge 3 (early mode).
- R4: `rdy_pull_o` goes low as soon as the strobe of the current access returns high, with no clock edge in between.
- R5: `data_oe_o` is low whenever `rd_n_i` is high.
- R6: A strobe that falls while the synchronized `cs_n_i` is high is ignored. It gives no ready and no store write.
- R7: A write strobe low for fewer than 4 clocks is not committed. One low for exactly 4 clocks is committed.
- R8: A strobe falling fewer than 6 clocks after the previous strobe fall is ignored. It gives no ready and no store write.
- R9: A write strobe falling less than 2 clocks after `cs_n_i` fell is ignored.
- R10: While reset is held, and after it is released, `rdy_pull_o` and `data_oe_o` are low.
- R11: `early_rdy_i` is sampled once, when the access starts. A change during the access does not alter that access's ready latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| early_rdy_i | input | 1 | 1 selects early ready latency, 0 selects normal |
| cs_n_i | input | 1 | Asynchronous chip select, active low |
| rd_n_i | input | 1 | Asynchronous read strobe, active low |
| wr_n_i | input | 1 | Asynchronous write strobe, active low |
| addr_i | input | 11 | Byte address |
| data_i | input | 8 | Write data from the data pads |
| data_o | output | 8 | Read data to the data pads |
| data_oe_o | output | 1 | Enable for the data pad drivers |
| rdy_pull_o | output | 1 | 1 means pull the ready pad low; 0 means release it |

## Verification
On every cycle, the assertions check four properties. The latched read byte stays put for the whole read. A store write happens only after a synchronized write strobe has been seen low. An access becomes active only when the synchronized select was low. Ready is entered only from the waiting state. The bench's scenarios are needed for everything that depends on exact timing or on stored contents. That covers the clock-exact ready latency in both modes, the release of ready and data at the moment a strobe rises, and the write capture point. It also covers the dropping of short, early or unselected strobes, which only shows up as missing ready and unchanged read-back data.

// File: rtl/abs_pkg.sv
// Shared types for the asynchronous bus slave.
package abs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } seq_state_t;

    typedef enum logic {
        ACC_RD = 1'b0,
        ACC_WR = 1'b1
    } acc_kind_t;
endpackage

// File: rtl/abs_sync_edge.sv
// Multi-bit synchronizer with edge detection.
// Each bit passes through STAGES flops, then one extra flop to find edges.
// Assumes: inputs are idle-high, active-low bus signals; STAGES >= 2.
module abs_sync_edge #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] fell_o,
    output logic [WIDTH-1:0] rose_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the raw pin into the chain; remember the last synchronized value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
                prev  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], async_i[b]};
                prev  <= chain[STAGES-1];
            end
        end

        assign level_o[b] = chain[STAGES-1];
        assign fell_o[b]  = prev & ~chain[STAGES-1];
        assign rose_o[b]  = ~prev & chain[STAGES-1];
    end
endmodule

// File: rtl/abs_byte_store.sv
// Byte array with an asynchronous read port and a synchronous write port.
// Assumes: the contents are not reset; the reader latches the data itself.
module abs_byte_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write one byte when the sequencer commits.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/abs_seq.sv
// Access sequencer: checks bus timing, times ready, and drives read data.
// Inputs are the synchronized levels and edges, plus the raw strobes. The
// raw strobes are used for capture enables and for combinational release.
// Assumes: address and data stay stable while a strobe is low.
module abs_seq
    import abs_pkg::*;
#(
    parameter int ADDR_W         = 11,
    parameter int DATA_W         = 8,
    parameter int SYNC_STAGES    = 2,
    parameter int NORMAL_LAT     = 5,
    parameter int EARLY_LAT      = 4,
    parameter int MIN_WR_CLKS    = 4,
    parameter int MIN_CYCLE_CLKS = 6,
    parameter int CS_TO_WR_CLKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              early_i,
    input  logic              cs_lvl,
    input  logic              wr_lvl,
    input  logic              rd_fell,
    input  logic              rd_rose,
    input  logic              wr_fell,
    input  logic              wr_rose,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    output logic              rdy_pull
);
    localparam int DETECT_LAT  = SYNC_STAGES + 1;
    localparam int NORMAL_NEED = NORMAL_LAT - DETECT_LAT;
    localparam int EARLY_NEED  = EARLY_LAT - DETECT_LAT;
    localparam int LAT_W       = $clog2(NORMAL_LAT + 1);
    localparam int GAP_MAX     = MIN_CYCLE_CLKS - 1;
    localparam int GAP_W       = $clog2(MIN_CYCLE_CLKS + 1);
    localparam int WRL_W       = $clog2(MIN_WR_CLKS + 1);
    localparam int CSC_W       = $clog2(CS_TO_WR_CLKS + 1);

    seq_state_t        st;
    acc_kind_t         kind;
    logic [LAT_W-1:0]  wait_cnt;
    logic [LAT_W-1:0]  need_sel;
    logic              early_q;
    logic [DATA_W-1:0] rd_q;
    logic              rd_valid;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [GAP_W-1:0]  gap_cnt;
    logic [WRL_W-1:0]  wr_len;
    logic [CSC_W-1:0]  cs_cnt;
    logic              gap_ok;
    logic              rd_go;
    logic              wr_go;
    logic              strobe_rose;
    logic              strobe_low;

    // Capture address and data while a strobe is low; the last sample wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            if (!rd_n_i || !wr_n_i) cap_addr <= addr_i;
            if (!wr_n_i)            cap_data <= data_i;
        end
    end

    // Count clocks since select fell, since the last strobe fall, and of write low time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_cnt  <= '0;
            gap_cnt <= GAP_W'(GAP_MAX);
            wr_len  <= '0;
        end else begin
            if (cs_lvl)                          cs_cnt <= '0;
            else if (cs_cnt != CSC_W'(CS_TO_WR_CLKS)) cs_cnt <= cs_cnt + 1'b1;

            if (rd_fell || wr_fell)              gap_cnt <= '0;
            else if (gap_cnt != GAP_W'(GAP_MAX)) gap_cnt <= gap_cnt + 1'b1;

            if (wr_lvl)                          wr_len <= '0;
            else if (wr_len != WRL_W'(MIN_WR_CLKS)) wr_len <= wr_len + 1'b1;
        end
    end

    assign gap_ok      = (gap_cnt == GAP_W'(GAP_MAX));
    assign rd_go       = (st == ST_IDLE) && rd_fell && !cs_lvl && gap_ok;
    assign wr_go       = (st == ST_IDLE) && wr_fell && !rd_fell && !cs_lvl && gap_ok
                         && (cs_cnt == CSC_W'(CS_TO_WR_CLKS));
    assign strobe_rose = (kind == ACC_RD) ? rd_rose : wr_rose;
    assign strobe_low  = (kind == ACC_RD) ? !rd_n_i : !wr_n_i;
    assign need_sel    = early_q ? LAT_W'(EARLY_NEED) : LAT_W'(NORMAL_NEED);

    // Access state machine: idle, waiting for ready latency, ready held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            kind     <= ACC_RD;
            wait_cnt <= '0;
            early_q  <= 1'b0;
            rd_q     <= '0;
            rd_valid <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (rd_go || wr_go) begin
                        st       <= ST_WAIT;
                        kind     <= rd_go ? ACC_RD : ACC_WR;
                        wait_cnt <= '0;
                        early_q  <= early_i;
                    end
                    if (rd_go) begin
                        rd_q     <= mem_rdata;
                        rd_valid <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (strobe_rose) begin
                        st       <= ST_IDLE;
                        rd_valid <= 1'b0;
                    end else if (wait_cnt == need_sel - 1'b1) begin
                        st <= ST_READY;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_READY: begin
                    if (strobe_rose) begin
                        st       <= ST_IDLE;
                        rd_valid <= 1'b0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_raddr = cap_addr;
    assign mem_waddr = cap_addr;
    assign mem_wdata = cap_data;
    assign mem_we    = (st != ST_IDLE) && (kind == ACC_WR) && wr_rose && !cs_lvl
                       && (wr_len == WRL_W'(MIN_WR_CLKS));
    assign data_o    = rd_q;
    assign data_oe   = rd_valid && !rd_n_i;
    assign rdy_pull  = (st == ST_READY) && strobe_low;

    // R1: latched read byte holds for the whole read.
    assert_rd_data_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid)) |-> $stable(data_o));

    // R7: a store write only follows a synchronized low write strobe.
    assert_wr_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(!wr_lvl));

    // R6: an access becomes active only with select low when it began.
    assert_start_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st != ST_IDLE) |-> $past(!cs_lvl));

    // R3: ready is only entered after the latency wait.
    assert_ready_after_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_READY) |-> $past(st == ST_WAIT));

    initial begin
        assert_lat_params_R3: assert (EARLY_NEED >= 1 && NORMAL_NEED >= EARLY_NEED);
    end
endmodule

// File: rtl/async_bus_slave.sv
// Top level: asynchronous microprocessor bus slave with a ready handshake.
// It synchronizes select and strobes, sequences each access into a local
// byte store, and returns pad enables for data and the open-drain ready.
// Assumes: the pad ring builds the tristate data and pull-down ready buffers.
module async_bus_slave #(
    parameter int ADDR_W         = 11,
    parameter int DATA_W         = 8,
    parameter int SYNC_STAGES    = 2,
    parameter int NORMAL_LAT     = 5,
    parameter int EARLY_LAT      = 4,
    parameter int MIN_WR_CLKS    = 4,
    parameter int MIN_CYCLE_CLKS = 6,
    parameter int CS_TO_WR_CLKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              early_rdy_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              rdy_pull_o
);
    localparam int B_RD = 0;
    localparam int B_WR = 1;
    localparam int B_CS = 2;

    logic [2:0]        lvl;
    logic [2:0]        fell;
    logic [2:0]        rose;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] rdata;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] wdata;

    abs_sync_edge #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n_i, wr_n_i, rd_n_i}),
        .level_o (lvl),
        .fell_o  (fell),
        .rose_o  (rose)
    );

    abs_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
        .NORMAL_LAT(NORMAL_LAT), .EARLY_LAT(EARLY_LAT),
        .MIN_WR_CLKS(MIN_WR_CLKS), .MIN_CYCLE_CLKS(MIN_CYCLE_CLKS),
        .CS_TO_WR_CLKS(CS_TO_WR_CLKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .early_i   (early_rdy_i),
        .cs_lvl    (lvl[B_CS]),
        .wr_lvl    (lvl[B_WR]),
        .rd_fell   (fell[B_RD]),
        .rd_rose   (rose[B_RD]),
        .wr_fell   (fell[B_WR]),
        .wr_rose   (rose[B_WR]),
        .rd_n_i    (rd_n_i),
        .wr_n_i    (wr_n_i),
        .addr_i    (addr_i),
        .data_i    (data_i),
        .mem_rdata (rdata),
        .mem_raddr (raddr),
        .mem_we    (we),
        .mem_waddr (waddr),
        .mem_wdata (wdata),
        .data_o    (data_o),
        .data_oe   (data_oe_o),
        .rdy_pull  (rdy_pull_o)
    );

    abs_byte_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .raddr (raddr),
        .rdata (rdata),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata)
    );
endmodule

// File: tb/async_bus_slave_test.sv
// Directed bench: one task per scenario, each checking its own results.
module async_bus_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        early_rdy_i = 1'b0;
    logic        cs_n_i = 1'b1;
    logic        rd_n_i = 1'b1;
    logic        wr_n_i = 1'b1;
    logic [10:0] addr_i = '0;
    logic [7:0]  data_i = '0;
    logic [7:0]  data_o;
    logic        data_oe_o;
    logic        rdy_pull_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    async_bus_slave uut (
        .clk(clk), .rst_n(rst_n), .early_rdy_i(early_rdy_i), .cs_n_i(cs_n_i),
        .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .addr_i(addr_i), .data_i(data_i),
        .data_o(data_o), .data_oe_o(data_oe_o), .rdy_pull_o(rdy_pull_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Move to 2 ns after the n-th next rising edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One strobe of len clocks; checks ready timeline, read data and release.
    task automatic access(input bit rd, input logic [10:0] a, input logic [7:0] d,
                          input int len, input bit early, input bit flip,
                          input bit exp_rdy, input logic [7:0] exp_rd, input string req);
        tick(1);
        early_rdy_i = early;
        addr_i = a;
        data_i = d;
        if (rd) rd_n_i = 1'b0; else wr_n_i = 1'b0;
        if (len >= 6) begin
            neg(4);
            check(rdy_pull_o == 1'b0, req, "ready too soon", rdy_pull_o, 0);
            if (flip) early_rdy_i = ~early;
            neg(1);
            check(rdy_pull_o == (exp_rdy & early), req, "ready at edge 4", rdy_pull_o, exp_rdy & early);
            neg(1);
            check(rdy_pull_o == exp_rdy, req, "ready at edge 5", rdy_pull_o, exp_rdy);
            if (rd && exp_rdy) begin
                check(data_oe_o == 1'b1, "R1", "read drive", data_oe_o, 1);
                check(data_o == exp_rd, "R1", "read data", data_o, exp_rd);
            end
            tick(len - 5);
            rd_n_i = 1'b1;
            wr_n_i = 1'b1;
            #1;
            check(rdy_pull_o == 1'b0, "R4", "ready after release", rdy_pull_o, 0);
            check(data_oe_o == 1'b0, "R5", "drive after release", data_oe_o, 0);
        end else begin
            tick(len);
            rd_n_i = 1'b1;
            wr_n_i = 1'b1;
            for (int i = 0; i < 6; i++) begin
                neg(1);
                check(rdy_pull_o == 1'b0, req, "ready after short strobe", rdy_pull_o, 0);
            end
        end
        early_rdy_i = 1'b0;
        tick(8);
    endtask

    task automatic t_reset;
        neg(1);
        check(rdy_pull_o == 1'b0, "R10", "ready in reset", rdy_pull_o, 0);
        check(data_oe_o == 1'b0, "R10", "drive in reset", data_oe_o, 0);
        tick(2);
        rst_n = 1'b1;
        cs_n_i = 1'b0;
        tick(6);
        check(rdy_pull_o == 1'b0, "R10", "ready after reset", rdy_pull_o, 0);
        check(data_oe_o == 1'b0, "R10", "drive after reset", data_oe_o, 0);
    endtask

    task automatic t_normal;
        access(1'b0, 11'h123, 8'h5A, 7, 1'b0, 1'b0, 1'b1, 8'h00, "R3");
        access(1'b1, 11'h123, 8'h00, 7, 1'b0, 1'b0, 1'b1, 8'h5A, "R2");
    endtask

    task automatic t_early;
        access(1'b0, 11'h7FF, 8'hC3, 6, 1'b1, 1'b0, 1'b1, 8'h00, "R3");
        access(1'b0, 11'h000, 8'h01, 9, 1'b0, 1'b0, 1'b1, 8'h00, "R3");
        access(1'b1, 11'h7FF, 8'h00, 6, 1'b1, 1'b0, 1'b1, 8'hC3, "R3");
        access(1'b1, 11'h000, 8'h00, 6, 1'b0, 1'b0, 1'b1, 8'h01, "R2");
    endtask

    task automatic t_cs_high;
        cs_n_i = 1'b1;
        tick(4);
        access(1'b0, 11'h123, 8'hEE, 7, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
        cs_n_i = 1'b0;
        tick(6);
        access(1'b1, 11'h123, 8'h00, 6, 1'b0, 1'b0, 1'b1, 8'h5A, "R6");
    endtask

    task automatic t_short_write;
        access(1'b0, 11'h123, 8'h11, 3, 1'b0, 1'b0, 1'b0, 8'h00, "R7");
        access(1'b1, 11'h123, 8'h00, 6, 1'b0, 1'b0, 1'b1, 8'h5A, "R7");
        access(1'b0, 11'h124, 8'h44, 4, 1'b0, 1'b0, 1'b0, 8'h00, "R7");
        access(1'b1, 11'h124, 8'h00, 6, 1'b0, 1'b0, 1'b1, 8'h44, "R7");
    endtask

    task automatic t_gap;
        tick(1);
        addr_i = 11'h123;
        rd_n_i = 1'b0;
        tick(2);
        rd_n_i = 1'b1;
        tick(2);
        data_i = 8'h99;
        wr_n_i = 1'b0;
        for (int i = 0; i < 7; i++) begin
            neg(1);
            check(rdy_pull_o == 1'b0, "R8", "ready on early strobe", rdy_pull_o, 0);
        end
        tick(1);
        wr_n_i = 1'b1;
        tick(8);
        access(1'b1, 11'h123, 8'h00, 6, 1'b0, 1'b0, 1'b1, 8'h5A, "R8");
    endtask

    task automatic t_cs_lead;
        cs_n_i = 1'b1;
        tick(4);
        cs_n_i = 1'b0;
        access(1'b0, 11'h123, 8'h77, 7, 1'b0, 1'b0, 1'b0, 8'h00, "R9");
        access(1'b1, 11'h123, 8'h00, 6, 1'b0, 1'b0, 1'b1, 8'h5A, "R9");
    endtask

    task automatic t_early_sampled;
        access(1'b1, 11'h124, 8'h00, 7, 1'b0, 1'b1, 1'b1, 8'h44, "R11");
        access(1'b1, 11'h7FF, 8'h00, 7, 1'b1, 1'b1, 1'b1, 8'hC3, "R11");
    endtask

    initial begin
        t_reset();
        t_normal();
        t_early();
        t_cs_high();
        t_short_write();
        t_gap();
        t_cs_lead();
        t_early_sampled();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule